// File: doc/BRIEF.md
# Serial-Clock-Paced SAR Conversion Port

This block is the digital half of a 12-bit successive-approximation converter whose conversion is paced by an external serial clock. There is no internal conversion clock. A host pulls the active-low select line low. The block then freezes the analog sample through a hold control and presents a first trial code to the capacitor DAC. From then on it resolves one result bit on every rising edge of the serial clock. The bit is streamed out on the data line as soon as it is decided. The comparator, the DAC and the track-and-hold are analog. Here they appear only as the `compHigh` input and the `holdOut` and `dacCode` outputs.

All pins are sampled into a local system clock domain through a short synchronizer. Every frame starts with fixed leading zeros, carries the result MSB first, and pads with zeros once the LSB has been shifted out. A select rise before the LSB is decided aborts the conversion. After an abort, a fresh start is accepted only once an acquisition window has passed. After a complete frame, only a short select-high recovery is needed. An active-low shutdown input gates the whole port.

Top module: `sclk_sar_port`

## Requirements
- R1: A falling edge of `csN` while the port is idle and out of shutdown sets `holdOut` and `doutEn`, and `doutData` reads 0.
- R2: While `csN` is high, `doutEn` and `holdOut` are 0 (tri-state data line, input tracking); this is also the reset state.
- R3: `doutData` changes only in response to a rising edge of `sclk`; falling edges leave it unchanged.
- R4: A frame has LEAD_ZEROS (3) zero bit slots: the level shown right after the select fall, plus the slots after rising edges 1 and 2. After rising edge 3+i the line carries result bit 11-i, so the MSB comes first and the LSB follows edge 14.
- R5: Rising edges after the LSB drive 0 on `doutData` and do not change the held result on `dacCode`.
- R6: `compHigh`=1 means the input is at or above the current trial level, and the bit under trial is then kept. With an ideal comparator whose thresholds sit half an LSB below each code, the final code is the input rounded to the nearest LSB, in straight binary, saturating at 4095.
- R7: At the start of a frame `dacCode` is 0x800. After each deciding edge, the bit under trial is kept or cleared and the next lower bit is set as the new trial.
- R8: If `csN` rises before the LSB is decided, the conversion is aborted, and a `csN` fall within ACQ_CYCLES system clocks of that rise is ignored. A fall after that window starts a frame normally.
- R9: After a complete frame, a `csN` fall about CSHIGH_CYCLES system clocks after the rise is accepted, well inside the abort window.
- R10: While `shdnN` is low, a `csN` fall is ignored and the data line stays tri-state. Driving `shdnN` high restores normal operation.
- R11: Driving `shdnN` low during a frame ends the frame: `doutEn` and `holdOut` fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low select; fall starts a frame, rise ends it |
| sclk | input | 1 | Serial clock; each rising edge advances the frame |
| shdnN | input | 1 | Active-low shutdown |
| compHigh | input | 1 | Comparator result: input at or above trial level |
| doutData | output | 1 | Serial data bit |
| doutEn | output | 1 | Output enable for the data pad (0 = high impedance) |
| holdOut | output | 1 | Track-and-hold control, 1 = hold |
| dacCode | output | 12 | Trial code to the capacitor DAC; holds the result after the LSB |

## Verification
An edge counter that is off by one shifts the whole frame by a slot. That shows on the data line at the first data slot, three serial edges into the frame, as a zero where the MSB of a mid-scale code belongs. A wrong trial-mask step shows on `dacCode` one serial edge after the bad decision and corrupts every later bit. A recovery counter loaded with the wrong window length shows as an accepted or refused select fall within a few dozen system clocks of the select rise.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;

  // Pin positions inside the synchronizer vector
  localparam int PIN_CS   = 0;
  localparam int PIN_SCLK = 1;
  localparam int PIN_SHDN = 2;
  localparam int PIN_COUNT = 3;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_IDLE,
    ST_FRAME,
    ST_RECOVER
  } portState_e;

  // Strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic start;   // load first trial, drive 0
    logic shift;   // a serial rising edge inside a frame
    logic decide;  // this edge resolves the bit under trial
  } sarStrobe_t;

endpackage

// File: rtl/sar_pin_sync.sv
module sar_pin_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_LEVEL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinRaw,
  output logic [WIDTH-1:0] levelNow,
  output logic [WIDTH-1:0] levelPrev
);

  logic [WIDTH-1:0] pipe [STAGES+1];

  genvar s;
  generate
    for (s = 0; s <= STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[0] <= RESET_LEVEL;
          else       pipe[0] <= pinRaw;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) pipe[s] <= RESET_LEVEL;
          else       pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign levelNow  = pipe[STAGES-1];
  assign levelPrev = pipe[STAGES];

endmodule

// File: rtl/sar_port_ctrl.sv
module sar_port_ctrl
  import sar_port_pkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int ACQ_CYCLES = 32,
  parameter int CSHIGH_CYCLES = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csNow,
  input  logic       csPrev,
  input  logic       sclkNow,
  input  logic       sclkPrev,
  input  logic       shdnNow,
  input  logic       shdnPrev,
  output sarStrobe_t stb,
  output logic       holdOut,
  output logic       outEn
);

  localparam int LAST_EDGE_I = LEAD_ZEROS + DATA_BITS - 1;
  localparam int EW = $clog2(LAST_EDGE_I + 2);
  localparam logic [EW:0] LEAD_E = (EW+1)'(LEAD_ZEROS);
  localparam logic [EW:0] LAST_E = (EW+1)'(LAST_EDGE_I);
  localparam logic [EW-1:0] EDGE_MAX = EW'(LAST_EDGE_I + 1);
  localparam int REC_MAX = (ACQ_CYCLES > CSHIGH_CYCLES) ? ACQ_CYCLES : CSHIGH_CYCLES;
  localparam int RW = $clog2(REC_MAX + 1);

  portState_e state, stateNext;
  logic [EW-1:0] edgeCnt, edgeNext;
  logic [RW-1:0] recCnt, recNext;
  logic [EW:0] edgeInc;
  logic csFall, csRise, sclkRise, shdnSteady;

  assign csFall     = csPrev & ~csNow;
  assign csRise     = ~csPrev & csNow;
  assign sclkRise   = ~sclkPrev & sclkNow;
  assign shdnSteady = shdnNow & shdnPrev;
  assign edgeInc    = {1'b0, edgeCnt} + 1'b1;

  always_comb begin
    stateNext = state;
    edgeNext  = edgeCnt;
    recNext   = recCnt;
    stb       = '0;
    case (state)
      ST_OFF: begin
        if (shdnSteady) stateNext = ST_IDLE;
      end
      ST_IDLE: begin
        if (!shdnNow) begin
          stateNext = ST_OFF;
        end else if (csFall) begin
          stateNext = ST_FRAME;
          stb.start = 1'b1;
          edgeNext  = '0;
        end
      end
      ST_FRAME: begin
        if (!shdnNow) begin
          stateNext = ST_OFF;
        end else if (csRise) begin
          stateNext = ST_RECOVER;
          if ({1'b0, edgeCnt} >= LAST_E) recNext = RW'(CSHIGH_CYCLES - 1);
          else                           recNext = RW'(ACQ_CYCLES - 1);
        end else if (sclkRise) begin
          stb.shift  = 1'b1;
          stb.decide = (edgeInc >= LEAD_E) && (edgeInc <= LAST_E);
          if (edgeCnt != EDGE_MAX) edgeNext = edgeInc[EW-1:0];
        end
      end
      ST_RECOVER: begin
        if (!shdnNow)          stateNext = ST_OFF;
        else if (recCnt == '0) stateNext = ST_IDLE;
        else                   recNext = recCnt - 1'b1;
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      edgeCnt <= '0;
      recCnt  <= '0;
      holdOut <= 1'b0;
      outEn   <= 1'b0;
    end else begin
      state   <= stateNext;
      edgeCnt <= edgeNext;
      recCnt  <= recNext;
      holdOut <= (stateNext == ST_FRAME);
      outEn   <= (stateNext == ST_FRAME);
    end
  end

endmodule

// File: rtl/sar_port_datapath.sv
module sar_port_datapath
  import sar_port_pkg::*;
#(
  parameter int DATA_BITS = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sarStrobe_t           stb,
  input  logic                 compHigh,
  output logic [DATA_BITS-1:0] dacCode,
  output logic                 doutData
);

  localparam logic [DATA_BITS-1:0] MSB_ONLY = {1'b1, {(DATA_BITS-1){1'b0}}};

  logic [DATA_BITS-1:0] sarReg, trialMask;

  assign dacCode = sarReg;

  genvar b;
  generate
    for (b = 0; b < DATA_BITS; b++) begin : g_bit
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sarReg[b] <= 1'b0;
        end else if (stb.start) begin
          sarReg[b] <= MSB_ONLY[b];
        end else if (stb.decide) begin
          if (trialMask[b]) begin
            sarReg[b] <= compHigh;
          end else begin
            if (b < DATA_BITS - 1) begin
              if (trialMask[(b < DATA_BITS - 1) ? b + 1 : b]) sarReg[b] <= 1'b1;
            end
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trialMask <= '0;
      doutData  <= 1'b0;
    end else if (stb.start) begin
      trialMask <= MSB_ONLY;
      doutData  <= 1'b0;
    end else if (stb.decide) begin
      trialMask <= trialMask >> 1;
      doutData  <= compHigh;
    end else if (stb.shift) begin
      doutData  <= 1'b0;
    end
  end

endmodule

// File: rtl/sclk_sar_port.sv
module sclk_sar_port
  import sar_port_pkg::*;
#(
  parameter int DATA_BITS = 12,
  parameter int LEAD_ZEROS = 3,
  parameter int SYNC_STAGES = 2,
  parameter int ACQ_CYCLES = 32,
  parameter int CSHIGH_CYCLES = 5
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 sclk,
  input  logic                 shdnN,
  input  logic                 compHigh,
  output logic                 doutData,
  output logic                 doutEn,
  output logic                 holdOut,
  output logic [DATA_BITS-1:0] dacCode
);

  localparam logic [PIN_COUNT-1:0] PIN_RESET = PIN_COUNT'(1 << PIN_CS);

  logic [PIN_COUNT-1:0] pinNow, pinPrev;
  sarStrobe_t ctrlStb;

  sar_pin_sync #(
    .WIDTH(PIN_COUNT),
    .STAGES(SYNC_STAGES),
    .RESET_LEVEL(PIN_RESET)
  ) u_sync (
    .clk(clk),
    .rstN(rstN),
    .pinRaw({shdnN, sclk, csN}),
    .levelNow(pinNow),
    .levelPrev(pinPrev)
  );

  sar_port_ctrl #(
    .DATA_BITS(DATA_BITS),
    .LEAD_ZEROS(LEAD_ZEROS),
    .ACQ_CYCLES(ACQ_CYCLES),
    .CSHIGH_CYCLES(CSHIGH_CYCLES)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .csNow(pinNow[PIN_CS]),
    .csPrev(pinPrev[PIN_CS]),
    .sclkNow(pinNow[PIN_SCLK]),
    .sclkPrev(pinPrev[PIN_SCLK]),
    .shdnNow(pinNow[PIN_SHDN]),
    .shdnPrev(pinPrev[PIN_SHDN]),
    .stb(ctrlStb),
    .holdOut(holdOut),
    .outEn(doutEn)
  );

  sar_port_datapath #(
    .DATA_BITS(DATA_BITS)
  ) u_data (
    .clk(clk),
    .rstN(rstN),
    .stb(ctrlStb),
    .compHigh(compHigh),
    .dacCode(dacCode),
    .doutData(doutData)
  );

endmodule

// File: rtl/sar_port_checker.sv
module sar_port_checker #(
  parameter int DATA_BITS = 12,
  parameter int SYNC_STAGES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 csN,
  input logic                 shdnN,
  input logic                 doutData,
  input logic                 doutEn,
  input logic                 holdOut,
  input logic [DATA_BITS-1:0] dacCode,
  input logic                 stbShift
);

  localparam int LIMIT = SYNC_STAGES + 2;
  localparam logic [DATA_BITS-1:0] MSB_ONLY = {1'b1, {(DATA_BITS-1){1'b0}}};

  int csHighRun, shdnLowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csHighRun  <= 0;
      shdnLowRun <= 0;
    end else begin
      if (!csN)                   csHighRun <= 0;
      else if (csHighRun < LIMIT) csHighRun <= csHighRun + 1;
      if (shdnN)                   shdnLowRun <= 0;
      else if (shdnLowRun < LIMIT) shdnLowRun <= shdnLowRun + 1;
    end
  end

  assert_tristate_cs_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    (csHighRun == LIMIT) |-> (!doutEn && !holdOut));

  assert_shutdown_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (shdnLowRun == LIMIT) |-> (!doutEn && !holdOut));

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doutEn) |-> (!doutData && holdOut));

  assert_dout_moves_on_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (doutEn && $past(doutEn) && (doutData != $past(doutData))) |-> $past(stbShift));

  assert_first_trial_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdOut) |-> (dacCode == MSB_ONLY));

endmodule

bind sclk_sar_port sar_port_checker #(
  .DATA_BITS(DATA_BITS),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .csN(csN),
  .shdnN(shdnN),
  .doutData(doutData),
  .doutEn(doutEn),
  .holdOut(holdOut),
  .dacCode(dacCode),
  .stbShift(ctrlStb.shift)
);

// File: tb/sclk_sar_port_tb.sv
module sclk_sar_port_tb;

  localparam int DW = 12;
  localparam int LEAD = 3;
  localparam int LAST = LEAD + DW - 1;
  localparam int FULL = (1 << DW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, csN, sclk, shdnN, compHigh;
  logic doutData, doutEn, holdOut;
  logic [DW-1:0] dacCode;
  int vinHalf = 0;

  // Ideal comparator: threshold of code T sits at T - 0.5 LSB
  assign compHigh = (vinHalf + 1) >= 2 * int'(dacCode);

  sclk_sar_port u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .shdnN(shdnN),
    .compHigh(compHigh), .doutData(doutData), .doutEn(doutEn),
    .holdOut(holdOut), .dacCode(dacCode)
  );

  int nChecks = 0;
  int nErrors = 0;

  typedef struct {
    logic  val;
    string tag;
  } expItem_t;
  expItem_t expQ[$];
  event sampleEv;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int roundCode(input int h);
    int c = (h + 1) / 2;
    return (c > FULL) ? FULL : c;
  endfunction

  function automatic logic expBit(input int code, input int e);
    if (e < LEAD || e > LAST) return 1'b0;
    return code[DW - 1 - (e - LEAD)];
  endfunction

  // Monitor: pops the scoreboard at each sample point
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() != 0) begin
        expItem_t it;
        it = expQ.pop_front();
        check(doutEn === 1'b1 && doutData === it.val, it.tag, "data slot",
              {doutEn, doutData}, {1'b1, it.val});
      end
    end
  end

  task automatic runFrame(input int h, input int nEdges, input int gap, input bit closeIt);
    int code;
    logic seen;
    vinHalf = h;
    code = roundCode(h);
    waitClk(gap);
    csN = 1'b0;
    waitClk(6);
    expQ.push_back('{1'b0, "R1"});
    ->sampleEv;
    check(holdOut === 1'b1, "R1", "hold at start", holdOut, 1);
    check(dacCode == 12'h800, "R7", "first trial", dacCode, 12'h800);
    for (int e = 1; e <= nEdges; e++) begin
      sclk = 1'b1;
      waitClk(4);
      seen = doutData;
      expQ.push_back('{expBit(code, e), (e > LAST) ? "R5" : "R4"});
      ->sampleEv;
      sclk = 1'b0;
      waitClk(4);
      check(doutData === seen, "R3", "falling edge moved data", doutData, seen);
      if (e >= LEAD && e <= LAST) begin
        int k = DW - 1 - (e - LEAD);
        int expDac = ((code >> k) << k) | ((k > 0) ? (1 << (k - 1)) : 0);
        check(int'(dacCode) == expDac, "R7", "trial code", dacCode, expDac);
      end else if (e > LAST) begin
        check(int'(dacCode) == code, "R5", "result after padding", dacCode, code);
      end
    end
    if (closeIt) begin
      csN = 1'b1;
      waitClk(6);
      check(doutEn === 1'b0, "R2", "enable after select high", doutEn, 0);
      check(holdOut === 1'b0, "R2", "hold after select high", holdOut, 0);
      if (nEdges >= LAST)
        check(int'(dacCode) == code, "R6", "final code", dacCode, code);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual=expired expected=done");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; csN = 1'b1; sclk = 1'b0; shdnN = 1'b1;
    waitClk(4);
    check(doutEn === 1'b0 && holdOut === 1'b0, "R2", "reset state",
          {doutEn, holdOut}, 0);
    rstN = 1'b1;
    waitClk(8);

    runFrame(2 * 12'hA5A + 1, 15, 40, 1'b1); // R6 half-LSB rounds up to A5B
    runFrame(0, 15, 40, 1'b1);               // R6 zero scale
    runFrame(8200, 18, 40, 1'b1);            // R5 padding, R6 saturation
    runFrame(2 * 12'h555, 17, 12, 1'b1);     // R9 short recovery after full frame
    runFrame(1, 15, 40, 1'b1);               // R6 0.5 LSB rounds to 1
    runFrame(2 * 12'h7FF, 15, 40, 1'b1);     // R6 just below mid-scale

    // R8: abort, then a quick restart is ignored
    runFrame(2 * 12'h3C3, 6, 40, 1'b0);
    csN = 1'b1;
    waitClk(10);
    csN = 1'b0;
    waitClk(8);
    check(doutEn === 1'b0, "R8", "start inside acquisition window", doutEn, 0);
    check(holdOut === 1'b0, "R8", "hold inside acquisition window", holdOut, 0);
    csN = 1'b1;
    waitClk(40);
    runFrame(2 * 12'h3C3, 15, 0, 1'b1);      // R8 accepted after the window

    // R10: shutdown ignores a start, wake restores operation
    shdnN = 1'b0;
    waitClk(6);
    csN = 1'b0;
    waitClk(8);
    check(doutEn === 1'b0, "R10", "enable in shutdown", doutEn, 0);
    check(holdOut === 1'b0, "R10", "hold in shutdown", holdOut, 0);
    csN = 1'b1;
    waitClk(4);
    shdnN = 1'b1;
    waitClk(8);
    runFrame(2 * 12'h0F0, 15, 10, 1'b1);     // R10 frame after wake

    // R11: shutdown in the middle of a frame
    runFrame(2 * 12'h9C4, 5, 40, 1'b0);
    shdnN = 1'b0;
    waitClk(6);
    check(doutEn === 1'b0, "R11", "enable after mid-frame shutdown", doutEn, 0);
    check(holdOut === 1'b0, "R11", "hold after mid-frame shutdown", holdOut, 0);
    csN = 1'b1;
    shdnN = 1'b1;
    waitClk(40);
    runFrame(2 * 12'hFFE, 15, 0, 1'b1);

    waitClk(4);
    summary();
    $finish;
  end

endmodule